// File: doc/BRIEF.md
# Serial Receiver with Flag-Carrying Receive Queue

This block recovers characters from an asynchronous serial line. An external baud generator supplies a one-cycle enable at sixteen times the bit rate. The receiver validates each start bit at the middle of its bit period. It then samples the data bits, the optional parity bit and the stop bit once each, at the centre of the bit. It writes the finished character into a queue, and each queue slot holds three status flags next to the byte: parity error, framing error and break.

The host or a DMA engine drains the queue through a show-ahead read port. The head entry is always visible, and a one-cycle read strobe removes it. Line status outputs report whether data is waiting and whether a character was lost because the queue was full. The lost-character flag is sticky until the host clears it. A request output tells a DMA engine that the queue holds at least a programmable number of entries. Character length, parity enable and parity sense come from static configuration inputs. The queue depth is a parameter: 16 by default, 64 as the larger option, and always a power of two.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: After reset the queue is empty: `level_o` is 0, and `data_ready_o`, `overrun_o` and `rxrdy_o` are all 0.
- R2: A low level on the line that has returned high by the 8th tick after the falling edge is not a start bit, and no character is stored.
- R3: Data bits arrive least significant bit first. `cfg_len_i` selects the length: 0 for 5 bits, 1 for 6, 2 for 7 and 3 for 8. Byte bits above the selected length read as 0.
- R4: When `cfg_par_en_i` is 1, a parity bit follows the data. `cfg_par_odd_i` = 0 selects even parity and 1 selects odd parity. A mismatch sets the entry's parity flag. When `cfg_par_en_i` is 0, the parity flag is always 0.
- R5: A stop bit sampled low on a character that is not a break sets the entry's framing flag, and the received byte is still stored.
- R6: A break is a frame in which the data bits, the parity bit (if enabled) and the stop bit all sample 0. It stores exactly one entry with byte 0x00, break flag 1, framing flag 1 and parity flag 0. No further character is accepted until the line has been high.
- R7: Entries leave the queue in arrival order. `level_o` gives the number of stored entries, which never exceeds DEPTH. `data_ready_o` is 1 exactly when `level_o` is nonzero.
- R8: A character that completes while the queue holds DEPTH entries is discarded, and the stored entries are unchanged. `overrun_o` is then set and stays 1 until `ovr_clr_i` is pulsed. If a new overrun coincides with the clear, the flag stays set.
- R9: A read strobe while the queue is empty has no effect on `level_o`.
- R10: `rxrdy_o` is 1 when `level_o` is at least `cfg_trig_i`. A trigger value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_len_i | input | 2 | Character length code (0..3 for 5..8 bits) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_trig_i | input | $clog2(DEPTH+1) | Entry count that raises the DMA request |
| rd_en_i | input | 1 | Pop the head entry |
| ovr_clr_i | input | 1 | Clear the sticky overrun flag |
| rd_data_o | output | 8 | Head entry byte |
| rd_perr_o | output | 1 | Head entry parity flag |
| rd_ferr_o | output | 1 | Head entry framing flag |
| rd_brk_o | output | 1 | Head entry break flag |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky lost-character flag |
| rxrdy_o | output | 1 | DMA request |
| level_o | output | $clog2(DEPTH+1) | Stored entry count |

## Verification
The bench uses the default DEPTH of 16 and a tick every fourth clock, so one bit lasts 64 clocks. With 16 slots, the bench can fill the queue with ordinary frames, drive a seventeenth character into a full queue, and then drain it to confirm that no stored entry was disturbed. The 4-clock tick spacing puts the sampling instants well inside each bit, even after the two-stage input synchronizer. The start-validation window can therefore be probed with a glitch of a quarter bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned MID_TICK      = 7;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    input  logic       tick_i,
    input  logic [1:0] cfg_len_i,
    input  logic       cfg_par_en_i,
    input  logic       cfg_par_odd_i,
    output logic       push_o,
    output rx_entry_t  entry_o
);
    typedef struct packed {
        rx_state_e state;
        logic [3:0] tcnt;
        logic [2:0] bidx;
        logic [7:0] shreg;
        logic       pbit;
        logic       push;
        rx_entry_t  entry;
    } framer_t;

    framer_t r_q, r_d;
    logic [2:0] last_idx;
    logic       is_brk;

    assign last_idx = 3'(cfg_len_i) + 3'd4;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        is_brk   = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (tick_i && !rxd_i) begin
                    r_d.state = ST_START;
                    r_d.tcnt  = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (r_q.tcnt == 4'(MID_TICK)) begin
                        if (!rxd_i) begin
                            r_d.state = ST_DATA;
                            r_d.tcnt  = '0;
                            r_d.bidx  = '0;
                            r_d.shreg = '0;
                            r_d.pbit  = 1'b0;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + 4'd1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (r_q.tcnt == 4'(TICKS_PER_BIT - 1)) begin
                        r_d.shreg[r_q.bidx] = rxd_i;
                        r_d.tcnt = '0;
                        if (r_q.bidx == last_idx)
                            r_d.state = cfg_par_en_i ? ST_PAR : ST_STOP;
                        else
                            r_d.bidx = r_q.bidx + 3'd1;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 4'd1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (r_q.tcnt == 4'(TICKS_PER_BIT - 1)) begin
                        r_d.pbit  = rxd_i;
                        r_d.tcnt  = '0;
                        r_d.state = ST_STOP;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 4'd1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (r_q.tcnt == 4'(TICKS_PER_BIT - 1)) begin
                        is_brk           = (r_q.shreg == 8'h00) && !r_q.pbit && !rxd_i;
                        r_d.push         = 1'b1;
                        r_d.entry.data   = r_q.shreg;
                        r_d.entry.ferr   = !rxd_i;
                        r_d.entry.brk    = is_brk;
                        r_d.entry.perr   = !is_brk && cfg_par_en_i &&
                                           ((^r_q.shreg ^ r_q.pbit) != cfg_par_odd_i);
                        r_d.tcnt         = '0;
                        r_d.state        = is_brk ? ST_BRKWAIT : ST_IDLE;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 4'd1;
                    end
                end
            end
            ST_BRKWAIT: begin
                if (rxd_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.tcnt  <= '0;
            r_q.bidx  <= '0;
            r_q.shreg <= '0;
            r_q.pbit  <= 1'b0;
            r_q.push  <= 1'b0;
            r_q.entry <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign push_o  = r_q.push;
    assign entry_o = r_q.entry;
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  rx_entry_t     entry_i,
    input  logic          pop_i,
    input  logic          ovr_clr_i,
    output rx_entry_t     head_o,
    output logic [CW-1:0] level_o,
    output logic          overrun_o
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic          ovr;
    } ctl_t;

    ctl_t c_q, c_d;
    rx_entry_t mem_q [DEPTH];
    logic full, empty, do_wr, do_rd;

    assign full  = (c_q.count == CW'(DEPTH));
    assign empty = (c_q.count == '0);
    assign do_wr = push_i && !full;
    assign do_rd = pop_i && !empty;

    always_comb begin
        c_d = c_q;
        if (do_wr)
            c_d.wptr = (c_q.wptr == AW'(DEPTH - 1)) ? '0 : c_q.wptr + AW'(1);
        if (do_rd)
            c_d.rptr = (c_q.rptr == AW'(DEPTH - 1)) ? '0 : c_q.rptr + AW'(1);
        case ({do_wr, do_rd})
            2'b10:   c_d.count = c_q.count + CW'(1);
            2'b01:   c_d.count = c_q.count - CW'(1);
            default: c_d.count = c_q.count;
        endcase
        if (ovr_clr_i) c_d.ovr = 1'b0;
        if (push_i && full) c_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[c_q.wptr] <= entry_i;
    end

    assign head_o    = empty ? '0 : mem_q[c_q.rptr];
    assign level_o   = c_q.count;
    assign overrun_o = c_q.ovr;
endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_i,
    input  logic          tick16_i,
    input  logic [1:0]    cfg_len_i,
    input  logic          cfg_par_en_i,
    input  logic          cfg_par_odd_i,
    input  logic [CW-1:0] cfg_trig_i,
    input  logic          rd_en_i,
    input  logic          ovr_clr_i,
    output logic [7:0]    rd_data_o,
    output logic          rd_perr_o,
    output logic          rd_ferr_o,
    output logic          rd_brk_o,
    output logic          data_ready_o,
    output logic          overrun_o,
    output logic          rxrdy_o,
    output logic [CW-1:0] level_o
);
    logic          rxd_s;
    logic          fr_push;
    rx_entry_t     fr_entry;
    rx_entry_t     head;
    logic [CW-1:0] lvl;
    logic [CW-1:0] trig_eff;

    rx_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (rxd_s)
    );

    rx_framer u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rxd_i         (rxd_s),
        .tick_i        (tick16_i),
        .cfg_len_i     (cfg_len_i),
        .cfg_par_en_i  (cfg_par_en_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .push_o        (fr_push),
        .entry_o       (fr_entry)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (fr_push),
        .entry_i   (fr_entry),
        .pop_i     (rd_en_i),
        .ovr_clr_i (ovr_clr_i),
        .head_o    (head),
        .level_o   (lvl),
        .overrun_o (overrun_o)
    );

    assign trig_eff     = (cfg_trig_i == '0) ? CW'(1) : cfg_trig_i;
    assign rd_data_o    = head.data;
    assign rd_perr_o    = head.perr;
    assign rd_ferr_o    = head.ferr;
    assign rd_brk_o     = head.brk;
    assign level_o      = lvl;
    assign data_ready_o = (lvl != '0);
    assign rxrdy_o      = (lvl >= trig_eff);
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input rx_entry_t     entry,
    input logic          rd_en,
    input logic          ovr_clr,
    input logic          overrun,
    input logic [CW-1:0] level
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R7

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        push && level == CW'(DEPTH) |=> overrun); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun); // R8

    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        push && !rd_en && level == CW'(DEPTH) |=> $stable(level)); // R8

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !push && level == '0 |=> level == '0); // R9

    AST_BRK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        push && entry.brk |-> entry.data == 8'h00 && entry.ferr && !entry.perr); // R6

    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R6
endmodule

bind uart_rx_fifo_top uart_rx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (fr_push),
    .entry   (fr_entry),
    .rd_en   (rd_en_i),
    .ovr_clr (ovr_clr_i),
    .overrun (overrun_o),
    .level   (level_o)
);

// File: tb/uart_rx_fifo_top_bench.sv
module uart_rx_fifo_top_bench;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int BITCLK = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          tick = 1'b0;
    logic [1:0]    cfg_len = 2'd3;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic [CW-1:0] trig = '0;
    logic          rd_en = 1'b0;
    logic          ovr_clr = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_perr, rd_ferr, rd_brk;
    logic          data_ready, overrun, rxrdy;
    logic [CW-1:0] level;

    int total = 0;
    int bad = 0;
    logic [1:0] tdiv = '0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    uart_rx_fifo_top #(.DEPTH(DEPTH)) u_uart_rx_fifo_top (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick),
        .cfg_len_i(cfg_len), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
        .cfg_trig_i(trig), .rd_en_i(rd_en), .ovr_clr_i(ovr_clr),
        .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr),
        .rd_brk_o(rd_brk), .data_ready_o(data_ready), .overrun_o(overrun),
        .rxrdy_o(rxrdy), .level_o(level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    // nbits 5..8; pmode 0 none, 1 even, 2 odd; flip inverts parity bit
    task automatic send(input logic [7:0] d, input int nbits, input int pmode,
                        input bit flip, input logic stopv);
        logic p;
        cfg_len = 2'(nbits - 5);
        par_en  = (pmode != 0);
        par_odd = (pmode == 2);
        hold_bit(1'b0);
        p = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            hold_bit(d[i]);
            p ^= d[i];
        end
        if (pmode != 0) hold_bit(p ^ (pmode == 2) ^ flip);
        hold_bit(stopv);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic pop_chk(input logic [7:0] d, input bit pe, input bit fe,
                           input bit bk, input string req);
        chk(rd_data == d, req, rd_data, d);
        chk({rd_perr, rd_ferr, rd_brk} == {pe, fe, bk}, req,
            {rd_perr, rd_ferr, rd_brk}, {pe, fe, bk});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(level == 0, "R1 level", level, 0);
        chk({data_ready, overrun, rxrdy} == 3'b000, "R1 flags",
            {data_ready, overrun, rxrdy}, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * BITCLK) @(negedge clk);
        chk(level == 0, "R2 glitch ignored", level, 0);
    endtask

    task automatic t_lengths();
        send(8'hA5, 8, 0, 0, 1'b1);
        send(8'hFF, 5, 0, 0, 1'b1);
        send(8'hD3, 6, 0, 0, 1'b1);
        send(8'h4E, 7, 0, 0, 1'b1);
        chk(level == 4, "R7 level", level, 4);
        chk(data_ready == 1'b1, "R7 data_ready", data_ready, 1);
        pop_chk(8'hA5, 0, 0, 0, "R3 len8");
        pop_chk(8'h1F, 0, 0, 0, "R3 len5");
        pop_chk(8'h13, 0, 0, 0, "R3 len6");
        pop_chk(8'h4E, 0, 0, 0, "R3 len7");
        chk(data_ready == 1'b0, "R7 drained", data_ready, 0);
    endtask

    task automatic t_parity();
        send(8'h37, 8, 1, 0, 1'b1);
        send(8'h37, 8, 1, 1, 1'b1);
        send(8'h5A, 7, 2, 0, 1'b1);
        send(8'h5A, 7, 2, 1, 1'b1);
        pop_chk(8'h37, 0, 0, 0, "R4 even ok");
        pop_chk(8'h37, 1, 0, 0, "R4 even bad");
        pop_chk(8'h5A, 0, 0, 0, "R4 odd ok");
        pop_chk(8'h5A, 1, 0, 0, "R4 odd bad");
    endtask

    task automatic t_framing();
        send(8'h81, 8, 0, 0, 1'b0);
        pop_chk(8'h81, 0, 1, 0, "R5 framing");
    endtask

    task automatic t_break();
        cfg_len = 2'd3;
        par_en  = 1'b1;
        par_odd = 1'b1;
        hold_bit(1'b0);
        repeat (20) hold_bit(1'b0);
        chk(level == 1, "R6 single entry", level, 1);
        hold_bit(1'b1);
        hold_bit(1'b1);
        send(8'h42, 8, 0, 0, 1'b1);
        chk(level == 2, "R6 resumes", level, 2);
        pop_chk(8'h00, 0, 1, 1, "R6 break entry");
        pop_chk(8'h42, 0, 0, 0, "R6 after break");
    endtask

    task automatic t_empty_pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk(level == 0, "R9 empty pop", level, 0);
    endtask

    task automatic t_trigger();
        trig = CW'(3);
        send(8'h01, 8, 0, 0, 1'b1);
        send(8'h02, 8, 0, 0, 1'b1);
        chk(rxrdy == 1'b0, "R10 below trig", rxrdy, 0);
        send(8'h03, 8, 0, 0, 1'b1);
        chk(rxrdy == 1'b1, "R10 at trig", rxrdy, 1);
        trig = '0;
        for (int i = 0; i < 3; i++) pop_chk(8'(i + 1), 0, 0, 0, "R7 order");
        chk(rxrdy == 1'b0, "R10 trig0 empty", rxrdy, 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < DEPTH; i++) send(8'(i + 16), 8, 0, 0, 1'b1);
        chk(level == DEPTH, "R7 full", level, DEPTH);
        chk(overrun == 1'b0, "R8 no ovr yet", overrun, 0);
        send(8'hEE, 8, 0, 0, 1'b1);
        chk(overrun == 1'b1, "R8 ovr set", overrun, 1);
        chk(level == DEPTH, "R8 level kept", level, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_chk(8'(i + 16), 0, 0, 0, "R8 contents");
        chk(overrun == 1'b1, "R8 sticky", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R8 cleared", overrun, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_glitch();
        t_lengths();
        t_parity();
        t_framing();
        t_break();
        t_empty_pop();
        t_trigger();
        t_overrun();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule